// File: doc/BRIEF.md
# Deferred Fault Token Tracker

This block sits beside the general register file and keeps one poison bit, the token, for every register. A speculative load that hits a fault does not trap. Its producer reports the fault on a writeback port, and the block records it by setting the destination's token. An operation that reads a poisoned source passes the token on to its own destination. The block also reports, in the same cycle, that the operation's own exception must be suppressed. So the poison follows the data through a whole chain of dependent operations.

A single check operation at the end of the chain reads one token. If the token is clear, the check does nothing. If it is set, the block requests a redirect in that same cycle, and the target is taken from the check's immediate. Memory access and the recovery code are outside this block. Register 0 always carries a clear token.

Top module: `dtok_tracker`

## Requirements
- R1: A synchronous active-low reset clears every token, and all read ports then return 0.
- R2: A writeback with its fault flag set (wb_fault=1) and no enabled source sets the destination token, and the token is visible on the read ports from the next cycle.
- R3: The new token is the OR of the fault flag and the tokens of the enabled sources (wb_use_a, wb_use_b). A source whose enable bit is 0 has no effect, even if its register is poisoned.
- R4: A writeback with no fault and no poisoned enabled source clears the destination token.
- R5: Register 0 always reads a token of 0. Writebacks to register 0 are ignored.
- R6: A check on a register with a clear token gives redir_valid=0 and redir_target=0 in the same cycle.
- R7: A check on a register with a set token gives redir_valid=1 and redir_target equal to chk_target in the same cycle.
- R8: When several writeback ports write the same register in one cycle, the highest-numbered port's token is stored.
- R9: Source tokens are read from the state before the current cycle's writebacks. There is no same-cycle forwarding between ports.
- R10: wb_poison for each port shows that port's computed token in the same cycle, with no register stage. The execution side uses it to suppress the operation's exception.
- R11: The read ports are combinational from the stored tokens, so a writeback becomes visible exactly one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_valid | input | NWB | Writeback valid, one bit per port |
| wb_dst | input | NWB x 7 | Destination register per port |
| wb_src_a | input | NWB x 7 | First source register per port |
| wb_src_b | input | NWB x 7 | Second source register per port |
| wb_use_a | input | NWB | First source is read by the operation |
| wb_use_b | input | NWB | Second source is read by the operation |
| wb_fault | input | NWB | Operation hit a fault whose exception is deferred |
| wb_poison | output | NWB | Token computed for this writeback; 1 means suppress the exception |
| rd_addr | input | NRD x 7 | Token read addresses |
| rd_tok | output | NRD | Token read data |
| chk_valid | input | 1 | Check operation present |
| chk_reg | input | 7 | Register tested by the check |
| chk_target | input | TGT_W | Recovery target immediate |
| redir_valid | output | 1 | Redirect to the recovery code requested |
| redir_target | output | TGT_W | Redirect target, 0 when no redirect |

## Verification
Three results have different timing. wb_poison, redir_valid and redir_target depend only on the inputs and the stored tokens in the current cycle. A token written by a writeback appears on rd_tok after exactly one rising edge. The bench drives new inputs on each falling edge and compares the combinational outputs a quarter period later, against a model array. It advances that model only at the following rising edge. A value written in cycle n is therefore expected on the read ports at cycle n+1 and never earlier.

// File: rtl/dtok_pkg.sv
// Package: default sizes shared by the token tracker modules.
// Assumes a power-of-two register count.
package dtok_pkg;
    localparam int DEF_NREG  = 128;
    localparam int DEF_NWB   = 2;
    localparam int DEF_NRD   = 2;
    localparam int DEF_TGT_W = 32;
endpackage

// File: rtl/dtok_merge.sv
// Token merge for one writeback port: ORs the fault flag with the tokens
// of the enabled sources. Assumes tok_vec is the pre-write state.
module dtok_merge #(
    parameter int NREG = dtok_pkg::DEF_NREG,
    localparam int AW  = $clog2(NREG)
) (
    input  logic [NREG-1:0] tok_vec,
    input  logic [AW-1:0]   src_a,
    input  logic [AW-1:0]   src_b,
    input  logic            use_a,
    input  logic            use_b,
    input  logic            fault,
    output logic            poison
);
    // Combine the fault flag with the source tokens.
    always_comb begin
        poison = fault | (use_a & tok_vec[src_a]) | (use_b & tok_vec[src_b]);
    end
endmodule

// File: rtl/dtok_array.sv
// Token storage: one bit per register, several write ports (the highest
// index wins on a collision), combinational read ports. Register 0 is never written.
module dtok_array #(
    parameter int NREG = dtok_pkg::DEF_NREG,
    parameter int NWB  = dtok_pkg::DEF_NWB,
    parameter int NRD  = dtok_pkg::DEF_NRD,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NWB-1:0]           we,
    input  logic [NWB-1:0][AW-1:0]   wa,
    input  logic [NWB-1:0]           wd,
    input  logic [NRD-1:0][AW-1:0]   ra,
    output logic [NRD-1:0]           rd,
    output logic [NREG-1:0]          tok_vec
);
    logic [NREG-1:0] tok_q;
    logic [NWB-1:0]  later_hit;

    // Store tokens; loop order gives the last port priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_q <= '0;
        end else begin
            for (int p = 0; p < NWB; p++) begin
                if (we[p] && wa[p] != '0) tok_q[wa[p]] <= wd[p];
            end
        end
    end

    // Flag ports that a higher-numbered port overrides in this cycle.
    always_comb begin
        later_hit = '0;
        for (int p = 0; p < NWB; p++) begin
            for (int q = p + 1; q < NWB; q++) begin
                if (we[q] && wa[q] == wa[p]) later_hit[p] = 1'b1;
            end
        end
    end

    // Read the ports.
    always_comb begin
        for (int r = 0; r < NRD; r++) rd[r] = tok_q[ra[r]];
    end

    assign tok_vec = tok_q;

    generate
        for (genvar p = 0; p < NWB; p++) begin : g_wchk
            // R8: the surviving writer's token lands in the array
            a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
                (we[p] && wa[p] != '0 && !later_hit[p]) |=> tok_q[$past(wa[p])] == $past(wd[p]));
        end
    endgenerate

    // R5: register 0 stays clear
    a_r5_zero_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !tok_q[0]);
endmodule

// File: rtl/dtok_check.sv
// Check unit: tests one token and requests a redirect in the same cycle.
// The target is zeroed when no redirect is requested.
module dtok_check #(
    parameter int NREG  = dtok_pkg::DEF_NREG,
    parameter int TGT_W = dtok_pkg::DEF_TGT_W,
    localparam int AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREG-1:0]  tok_vec,
    input  logic             chk_valid,
    input  logic [AW-1:0]    chk_reg,
    input  logic [TGT_W-1:0] chk_target,
    output logic             redir_valid,
    output logic [TGT_W-1:0] redir_target
);
    // Decide on a redirect and gate the target.
    always_comb begin
        redir_valid  = chk_valid & tok_vec[chk_reg];
        redir_target = redir_valid ? chk_target : '0;
    end

    // R6: without a redirect the target stays zero
    a_r6_quiet_target: assert property (@(posedge clk) disable iff (!rst_n)
        !redir_valid |-> redir_target == '0);
    // R7: a redirect always comes from a check
    a_r7_needs_check: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> chk_valid);
endmodule

// File: rtl/dtok_tracker.sv
// Deferred fault token tracker top: per-port token merge, token storage
// and the check unit. Assumes the writeback ports carry final results.
module dtok_tracker #(
    parameter int NREG  = dtok_pkg::DEF_NREG,
    parameter int NWB   = dtok_pkg::DEF_NWB,
    parameter int NRD   = dtok_pkg::DEF_NRD,
    parameter int TGT_W = dtok_pkg::DEF_TGT_W,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NWB-1:0]         wb_valid,
    input  logic [NWB-1:0][AW-1:0] wb_dst,
    input  logic [NWB-1:0][AW-1:0] wb_src_a,
    input  logic [NWB-1:0][AW-1:0] wb_src_b,
    input  logic [NWB-1:0]         wb_use_a,
    input  logic [NWB-1:0]         wb_use_b,
    input  logic [NWB-1:0]         wb_fault,
    output logic [NWB-1:0]         wb_poison,
    input  logic [NRD-1:0][AW-1:0] rd_addr,
    output logic [NRD-1:0]         rd_tok,
    input  logic                   chk_valid,
    input  logic [AW-1:0]          chk_reg,
    input  logic [TGT_W-1:0]       chk_target,
    output logic                   redir_valid,
    output logic [TGT_W-1:0]       redir_target
);
    logic [NREG-1:0] tok_vec;

    generate
        for (genvar p = 0; p < NWB; p++) begin : g_merge
            dtok_merge #(.NREG(NREG)) u_merge (
                .tok_vec(tok_vec),
                .src_a  (wb_src_a[p]),
                .src_b  (wb_src_b[p]),
                .use_a  (wb_use_a[p]),
                .use_b  (wb_use_b[p]),
                .fault  (wb_fault[p]),
                .poison (wb_poison[p])
            );
            // R2: a faulting writeback reports poison
            a_r2_fault_poisons: assert property (@(posedge clk) disable iff (!rst_n)
                wb_fault[p] |-> wb_poison[p]);
        end
        for (genvar r = 0; r < NRD; r++) begin : g_rdchk
            // R5: register 0 reads clear
            a_r5_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
                rd_addr[r] == '0 |-> !rd_tok[r]);
            // R1: the cycle after reset every token reads clear
            a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(rst_n) |-> !rd_tok[r]);
        end
    endgenerate

    dtok_array #(.NREG(NREG), .NWB(NWB), .NRD(NRD)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wb_valid),
        .wa     (wb_dst),
        .wd     (wb_poison),
        .ra     (rd_addr),
        .rd     (rd_tok),
        .tok_vec(tok_vec)
    );

    dtok_check #(.NREG(NREG), .TGT_W(TGT_W)) u_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .tok_vec     (tok_vec),
        .chk_valid   (chk_valid),
        .chk_reg     (chk_reg),
        .chk_target  (chk_target),
        .redir_valid (redir_valid),
        .redir_target(redir_target)
    );

    // R7: the check agrees with the read port on the same register
    a_r7_check_vs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && rd_addr[0] == chk_reg) |-> redir_valid == rd_tok[0]);
endmodule

// File: tb/sim_dtok_tracker.sv
// Bench: random and directed stimulus checked against a token model.
module sim_dtok_tracker;
    localparam int CLK_P = 10;
    localparam int NREG = 128, NWB = 2, NRD = 2, TGT_W = 32, AW = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NWB-1:0]         wb_valid = '0, wb_use_a = '0, wb_use_b = '0, wb_fault = '0;
    logic [NWB-1:0][AW-1:0] wb_dst = '0, wb_src_a = '0, wb_src_b = '0;
    logic [NWB-1:0]         wb_poison;
    logic [NRD-1:0][AW-1:0] rd_addr = '0;
    logic [NRD-1:0]         rd_tok;
    logic                   chk_valid = 1'b0, redir_valid;
    logic [AW-1:0]          chk_reg = '0;
    logic [TGT_W-1:0]       chk_target = '0, redir_target;

    int nvec = 0, nfail = 0;
    bit done = 0;
    logic [NREG-1:0] model = '0;

    always #(CLK_P/2) clk = ~clk;

    dtok_tracker u0 (.*);

    task automatic cmp(input string tag, input longint act, input longint exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic mpoison(input int p);
        return wb_fault[p] | (wb_use_a[p] & model[wb_src_a[p]]) | (wb_use_b[p] & model[wb_src_b[p]]);
    endfunction

    // Check the combinational outputs, then advance the model at the rising edge.
    task automatic settle(input string tag);
        logic [NREG-1:0] nxt;
        #(CLK_P/4);
        nxt = model;
        for (int p = 0; p < NWB; p++) begin
            cmp($sformatf("%s wb_poison[%0d] R10", tag, p), wb_poison[p], mpoison(p));
            if (wb_valid[p] && wb_dst[p] != 0) nxt[wb_dst[p]] = mpoison(p);
        end
        for (int r = 0; r < NRD; r++)
            cmp($sformatf("%s rd_tok[%0d] R11", tag, r), rd_tok[r], model[rd_addr[r]]);
        cmp($sformatf("%s redir_valid R6 R7", tag), redir_valid, chk_valid & model[chk_reg]);
        cmp($sformatf("%s redir_target R6 R7", tag), redir_target,
            (chk_valid & model[chk_reg]) ? chk_target : 0);
        @(posedge clk);
        model = nxt;
        @(negedge clk);
    endtask

    task automatic idle();
        wb_valid = '0; wb_use_a = '0; wb_use_b = '0; wb_fault = '0; chk_valid = 0;
    endtask

    task automatic wr(input int p, input int d, input int a, input int ua,
                      input int b, input int ub, input int f);
        wb_valid[p] = 1; wb_dst[p] = AW'(d); wb_src_a[p] = AW'(a); wb_use_a[p] = ua[0];
        wb_src_b[p] = AW'(b); wb_use_b[p] = ub[0]; wb_fault[p] = f[0];
    endtask

    task automatic expect_tok(input int a, input int e, input string tag);
        idle(); rd_addr[0] = AW'(a);
        #1; cmp(tag, rd_tok[0], e);
        settle(tag);
    endtask

    task automatic do_reset();
        idle(); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1; model = '0;
    endtask

    initial begin
        void'($urandom(32'h5eed));
        @(negedge clk);
        do_reset();
        // R1: all tokens clear after reset
        for (int i = 0; i < NREG; i += 2) begin
            idle(); rd_addr[0] = AW'(i); rd_addr[1] = AW'(i + 1);
            #1; cmp("R1 reset read0", rd_tok[0], 0); cmp("R1 reset read1", rd_tok[1], 0);
            settle("R1");
        end
        // R2: faulting speculative load sets token
        idle(); wr(0, 3, 0, 0, 0, 0, 1); settle("R2");
        expect_tok(3, 1, "R2 token set");
        // R3: propagation through enabled source, ignore disabled
        idle(); wr(0, 4, 3, 1, 0, 0, 0); wr(1, 6, 3, 0, 3, 0, 0); settle("R3");
        expect_tok(4, 1, "R3 propagated");
        expect_tok(6, 0, "R3 disabled source ignored");
        idle(); wr(1, 8, 1, 1, 4, 1, 0); settle("R3b");
        expect_tok(8, 1, "R3 second source");
        // R7 / R6: checks
        idle(); chk_valid = 1; chk_reg = 7'd4; chk_target = 32'hCAFE_0040;
        #1; cmp("R7 redirect", redir_valid, 1); cmp("R7 target", redir_target, 32'hCAFE_0040);
        settle("R7");
        idle(); chk_valid = 1; chk_reg = 7'd6; chk_target = 32'h1234;
        #1; cmp("R6 no redirect", redir_valid, 0); cmp("R6 target zero", redir_target, 0);
        settle("R6");
        // R4: clean write clears
        idle(); wr(0, 3, 0, 0, 0, 0, 0); settle("R4");
        expect_tok(3, 0, "R4 cleared");
        // R5: register 0
        idle(); wr(0, 0, 0, 0, 0, 0, 1); settle("R5");
        expect_tok(0, 0, "R5 reg0 stays clear");
        // R8: collision, last port wins
        idle(); wr(0, 7, 0, 0, 0, 0, 1); wr(1, 7, 0, 0, 0, 0, 0); settle("R8");
        expect_tok(7, 0, "R8 port1 clean wins");
        idle(); wr(0, 7, 0, 0, 0, 0, 0); wr(1, 7, 0, 0, 0, 0, 1); settle("R8b");
        expect_tok(7, 1, "R8 port1 fault wins");
        // R9: no same-cycle forwarding (r4 set, port0 clears, port1 reads old)
        idle(); wr(0, 4, 0, 0, 0, 0, 0); wr(1, 9, 4, 1, 0, 0, 0);
        #1; cmp("R9 old value seen", wb_poison[1], 1);
        settle("R9");
        expect_tok(9, 1, "R9 stored from old");
        expect_tok(4, 0, "R9 writer cleared");
        // Random mix over a small register window
        for (int n = 0; n < 3000; n++) begin
            idle();
            for (int p = 0; p < NWB; p++) begin
                wb_valid[p] = $urandom_range(0, 3) != 0;
                wb_dst[p] = AW'($urandom_range(0, 15));
                wb_src_a[p] = AW'($urandom_range(0, 15));
                wb_src_b[p] = AW'($urandom_range(0, 15));
                wb_use_a[p] = $urandom_range(0, 1) != 0;
                wb_use_b[p] = $urandom_range(0, 1) != 0;
                wb_fault[p] = $urandom_range(0, 5) == 0;
            end
            for (int r = 0; r < NRD; r++) rd_addr[r] = AW'($urandom_range(0, 15));
            chk_valid = $urandom_range(0, 1) != 0;
            chk_reg = AW'($urandom_range(0, 15));
            chk_target = $urandom;
            settle("rand R3");
        end
        // R1: mid-run reset clears everything
        do_reset();
        for (int i = 0; i < 16; i++) expect_tok(i, 0, "R1 mid-run reset");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule